// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block keeps a 512-row fast-page DRAM refreshed. It counts clock cycles and raises a refresh request at a fixed interval. The request goes to the memory access arbiter over a request/grant pair. Once granted, the block drives the row and column strobes for one refresh cycle. A mode input picks between two kinds of refresh cycle. In the first, CAS falls before RAS, so the DRAM supplies the row address itself. In the second, only RAS is strobed and the block drives a 9-bit row address from its own counter. That counter steps through all 512 rows.

The block also moves the DRAM into and out of self refresh. A self-refresh request is taken only in the last cycle of a finished refresh cycle. The block then holds both strobes low for at least a minimum pulse width. When the request is removed, RAS returns high for one precharge cycle. A refresh cycle then starts at once, without waiting for a grant, and the interval count starts again. This keeps both gaps short: the gap from the last refresh to self-refresh entry, and the gap from self-refresh exit to the next refresh. The allowed gap depends on the mode. It is loose in CAS-before-RAS mode and tight in RAS-only mode.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is held and at reset release, the outputs are as follows. `ras_n` and `cas_n` are 1. `arb_req`, `addr_en`, `cyc_done`, `sr_active` and `miss_err` are 0. `row_addr` is 0.
- R2: The refresh interval depends on the mode. With `ras_only`=0 it is CBR_PERIOD cycles and with `ras_only`=1 it is RO_PERIOD cycles. After reset release, `arb_req` is first seen high after that many rising edges. If each request is granted at once, the next request rises exactly one interval after the previous one.
- R3: Once raised, `arb_req` stays high until `arb_gnt` is seen, and the strobes stay idle while it waits. `arb_req` also stays high through the whole refresh cycle it leads to. It falls only in the cycle after `cyc_done`.
- R4: A CAS-before-RAS cycle (`ras_only`=0) runs as follows. First there is one cycle with `cas_n`=0 and `ras_n`=1. Then both strobes are 0 for RAS_LOW_CYC cycles, with `addr_en`=0. Last comes one cycle with both strobes high and `cyc_done`=1.
- R5: A RAS-only cycle (`ras_only`=1) holds `ras_n`=0 for RAS_LOW_CYC cycles. During those cycles `cas_n` is 1, `addr_en` is 1 and `row_addr` holds the current row count. The cycle ends with one cycle with both strobes high and `cyc_done`=1.
- R6: The row count rises by one after each RAS-only cycle and wraps from 511 to 0. A CAS-before-RAS cycle leaves the row count unchanged.
- R7: `miss_err` goes to 1 when a new interval expires while the previous request has not been granted. It stays at 1 until reset.
- R8: `sr_req` is sampled only in a cycle with `cyc_done`=1. A pulse on `sr_req` at any other time has no effect: `sr_active` and the strobes do not change.
- R9: On self-refresh entry there is one cycle with `cas_n`=0, `ras_n`=1 and `sr_active`=1, then both strobes go low. RAS falls RAS_LOW_CYC+2 cycles after the RAS fall of the last refresh cycle. This must not exceed the entry gap limit for the mode.
- R10: In self refresh, `ras_n` stays low for at least SR_MIN_CYC cycles, even if `sr_req` is removed earlier. It stays low for as long as `sr_req` stays high. It rises in the cycle after `sr_req` is seen low, once the minimum has passed.
- R11: On exit, one cycle follows with both strobes high, `sr_active`=0 and `arb_req`=1. Then a refresh cycle of the current mode starts without `arb_gnt`. The gap from the RAS rise to the next RAS fall is 2 cycles in CAS-before-RAS mode and 1 cycle in RAS-only mode. It must not exceed the exit gap limit.
- R12: The interval count restarts on exit. The next `arb_req` rises exactly one interval plus one cycle after the exit precharge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only | input | 1 | 0 selects CAS-before-RAS refresh, 1 selects RAS-only refresh |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| arb_gnt | input | 1 | Arbiter grant for a pending refresh request |
| arb_req | output | 1 | Request for the DRAM strobes, held through the cycle or self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_en | output | 1 | Row address is driven on `row_addr` |
| row_addr | output | ROW_BITS | Row count for RAS-only refresh |
| cyc_done | output | 1 | Last (precharge) cycle of a refresh cycle |
| sr_active | output | 1 | DRAM is held in self refresh |
| miss_err | output | 1 | Sticky missed-refresh flag |

## Verification
The bench builds the block with intervals of 40 and 20 cycles, a three-cycle RAS low time, a ten-cycle self-refresh minimum and gap limits of 30 and 12 cycles. With an interval that short, the bench can step the row count through all 512 rows and past the wrap within about ten thousand cycles. It checks every row value on the address pins. The small minimum makes both self-refresh exit paths quick to reach in both modes. One path releases the request early and the other holds it past the minimum. The entry and exit gaps and the restarted interval are then measured on the strobes to the exact cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAS_LEAD,
    ST_RAS_ON,
    ST_PRECH,
    ST_SR_CAS,
    ST_SR_HOLD,
    ST_SR_EXIT
  } rsq_state_e;

  // Choose a per-mode quantity: the RAS-only value or the CAS-before-RAS value.
  function automatic int unsigned by_mode(input logic ras_only,
                                          input int unsigned cbr_val,
                                          input int unsigned ro_val);
    return ras_only ? ro_val : cbr_val;
  endfunction

  // Saturating increment used by elapsed-time counters.
  function automatic int unsigned sat_inc(input int unsigned v);
    return (v == 32'hFFFF_FFFF) ? v : v + 1;
  endfunction

endpackage

// File: rtl/rsq_interval_timer.sv
module rsq_interval_timer #(
  parameter int unsigned CBR_PERIOD = 12500,
  parameter int unsigned RO_PERIOD  = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_only,
  input  logic clear,
  output logic due
);
  import rsq_pkg::*;

  localparam int unsigned MAXP = (CBR_PERIOD > RO_PERIOD) ? CBR_PERIOD : RO_PERIOD;
  localparam int TW = $clog2(MAXP + 1);

  logic [TW-1:0] elapsed;
  int unsigned   limit;

  always_comb limit = by_mode(ras_only, CBR_PERIOD, RO_PERIOD) - 1;

  // Greater-or-equal so a switch to a shorter interval still fires.
  assign due = !clear && (32'(elapsed) >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            elapsed <= '0;
    else if (clear || due) elapsed <= '0;
    else                   elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/rsq_row_counter.sv
module rsq_row_counter #(
  parameter int ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output logic [ROW_BITS-1:0] row
);
  localparam logic [ROW_BITS-1:0] LAST_ROW = '1;

  function automatic logic [ROW_BITS-1:0] row_next(input logic [ROW_BITS-1:0] r);
    return (r == LAST_ROW) ? '0 : r + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row_next(row);
  end
endmodule

// File: rtl/rsq_strobe_fsm.sv
module rsq_strobe_fsm #(
  parameter int unsigned RAS_LOW_CYC = 4,
  parameter int unsigned SR_MIN_CYC  = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_only,
  input  logic pending,
  input  logic arb_gnt,
  input  logic sr_req,
  output logic cyc_start,
  output logic cyc_done,
  output logic cyc_cbr,
  output logic busy,
  output logic in_sr,
  output logic sr_active,
  output logic ras_n,
  output logic cas_n,
  output logic addr_en
);
  import rsq_pkg::*;

  localparam int unsigned MAXPH = (RAS_LOW_CYC > SR_MIN_CYC) ? RAS_LOW_CYC : SR_MIN_CYC;
  localparam int PW = $clog2(MAXPH + 1);

  rsq_state_e    st, st_d;
  logic [PW-1:0] ph, ph_d;
  logic          cbr_d;
  logic          ras_last, sr_min_met;

  assign cyc_start  = (st == ST_IDLE) && pending && arb_gnt;
  assign ras_last   = 32'(ph) >= RAS_LOW_CYC - 1;
  assign sr_min_met = 32'(ph) >= SR_MIN_CYC - 1;

  always_comb begin
    st_d  = st;
    ph_d  = ph;
    cbr_d = cyc_cbr;
    unique case (st)
      ST_IDLE: if (cyc_start) begin
        cbr_d = !ras_only;
        ph_d  = '0;
        st_d  = ras_only ? ST_RAS_ON : ST_CAS_LEAD;
      end
      ST_CAS_LEAD: begin
        ph_d = '0;
        st_d = ST_RAS_ON;
      end
      ST_RAS_ON: begin
        if (ras_last) begin
          ph_d = '0;
          st_d = ST_PRECH;
        end else begin
          ph_d = ph + 1'b1;
        end
      end
      ST_PRECH: st_d = sr_req ? ST_SR_CAS : ST_IDLE;
      ST_SR_CAS: begin
        ph_d = '0;
        st_d = ST_SR_HOLD;
      end
      ST_SR_HOLD: begin
        if (sr_min_met && !sr_req) st_d = ST_SR_EXIT;
        else if (!sr_min_met)      ph_d = ph + 1'b1;
      end
      ST_SR_EXIT: begin
        // Exit refresh goes out at once, with no grant needed.
        cbr_d = !ras_only;
        ph_d  = '0;
        st_d  = ras_only ? ST_RAS_ON : ST_CAS_LEAD;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= '0;
      cyc_cbr <= 1'b1;
    end else begin
      st      <= st_d;
      ph      <= ph_d;
      cyc_cbr <= cbr_d;
    end
  end

  assign cyc_done  = (st == ST_PRECH);
  assign busy      = (st != ST_IDLE);
  assign sr_active = (st == ST_SR_CAS) || (st == ST_SR_HOLD);
  assign in_sr     = sr_active || (st == ST_SR_EXIT);
  assign ras_n     = !((st == ST_RAS_ON) || (st == ST_SR_HOLD));
  assign cas_n     = !((st == ST_CAS_LEAD) || (st == ST_SR_CAS) || (st == ST_SR_HOLD)
                       || ((st == ST_RAS_ON) && cyc_cbr));
  assign addr_en   = (st == ST_RAS_ON) && !cyc_cbr;
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq #(
  parameter int          ROW_BITS    = 9,
  parameter int unsigned CBR_PERIOD  = 12500,
  parameter int unsigned RO_PERIOD   = 800,
  parameter int unsigned RAS_LOW_CYC = 4,
  parameter int unsigned SR_MIN_CYC  = 5000,
  parameter int unsigned CBR_GAP     = 12500,
  parameter int unsigned RO_GAP      = 800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_only,
  input  logic                sr_req,
  input  logic                arb_gnt,
  output logic                arb_req,
  output logic                ras_n,
  output logic                cas_n,
  output logic                addr_en,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                cyc_done,
  output logic                sr_active,
  output logic                miss_err
);
  // Named internal events, visible to the bound checker.
  logic due, pending, cyc_start, cyc_cbr, busy, in_sr, row_step, miss_now;

  rsq_interval_timer #(
    .CBR_PERIOD(CBR_PERIOD),
    .RO_PERIOD (RO_PERIOD)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_only(ras_only),
    .clear   (in_sr),
    .due     (due)
  );

  rsq_strobe_fsm #(
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .SR_MIN_CYC (SR_MIN_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_only (ras_only),
    .pending  (pending),
    .arb_gnt  (arb_gnt),
    .sr_req   (sr_req),
    .cyc_start(cyc_start),
    .cyc_done (cyc_done),
    .cyc_cbr  (cyc_cbr),
    .busy     (busy),
    .in_sr    (in_sr),
    .sr_active(sr_active),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .addr_en  (addr_en)
  );

  assign row_step = cyc_done && !cyc_cbr;

  rsq_row_counter #(
    .ROW_BITS(ROW_BITS)
  ) u_rows (
    .clk  (clk),
    .rst_n(rst_n),
    .step (row_step),
    .row  (row_addr)
  );

  assign miss_now = due && pending && !cyc_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      miss_err <= 1'b0;
    end else begin
      if (in_sr)          pending <= 1'b0;
      else if (due)       pending <= 1'b1;
      else if (cyc_start) pending <= 1'b0;
      if (miss_now) miss_err <= 1'b1;
    end
  end

  assign arb_req = pending || busy;
endmodule

// File: rtl/dram_rfsh_seq_chk.sv
module dram_rfsh_seq_chk #(
  parameter int          ROW_BITS    = 9,
  parameter int unsigned SR_MIN_CYC  = 5000,
  parameter int unsigned CBR_GAP     = 12500,
  parameter int unsigned RO_GAP      = 800
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ras_n,
  input logic                cas_n,
  input logic                addr_en,
  input logic [ROW_BITS-1:0] row_addr,
  input logic                arb_req,
  input logic                sr_req,
  input logic                sr_active,
  input logic                miss_err,
  input logic                cyc_done,
  input logic                cyc_cbr,
  input logic                row_step
);
  import rsq_pkg::*;

  logic        ras_q, sr_q, after_sr;
  int unsigned since_fall, since_rise, hold_n, gap_lim;
  logic        fall_now, rise_now;

  assign fall_now = ras_q && !ras_n;
  assign rise_now = !ras_q && ras_n;
  always_comb gap_lim = by_mode(!cyc_cbr, CBR_GAP, RO_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1; sr_q <= 1'b0; after_sr <= 1'b0;
      since_fall <= 0; since_rise <= 0; hold_n <= 0;
    end else begin
      ras_q      <= ras_n;
      sr_q       <= sr_active;
      since_fall <= fall_now ? 1 : sat_inc(since_fall);
      since_rise <= rise_now ? 1 : sat_inc(since_rise);
      if (sr_q && !sr_active) after_sr <= 1'b1;
      else if (fall_now)      after_sr <= 1'b0;
      if (!sr_active)         hold_n <= 0;
      else if (!ras_n)        hold_n <= sat_inc(hold_n);
    end
  end

  a_r3_req_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_req) |-> $past(cyc_done));

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  a_r5_addr_with_ras_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n) |-> addr_en);

  a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    row_step |=> row_addr == ROW_BITS'($past(row_addr) + 1'b1));

  a_r6_row_still: assert property (@(posedge clk) disable iff (!rst_n)
    !row_step |=> $stable(row_addr));

  a_r7_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |=> miss_err);

  a_r8_sr_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_active) |-> $past(cyc_done && sr_req));

  a_r9_entry_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_now && sr_active) |-> since_fall <= gap_lim);

  a_r10_sr_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> hold_n >= SR_MIN_CYC);

  a_r11_exit_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_now && after_sr) |-> since_rise <= gap_lim);
endmodule

bind dram_rfsh_seq dram_rfsh_seq_chk #(
  .ROW_BITS  (ROW_BITS),
  .SR_MIN_CYC(SR_MIN_CYC),
  .CBR_GAP   (CBR_GAP),
  .RO_GAP    (RO_GAP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .addr_en  (addr_en),
  .row_addr (row_addr),
  .arb_req  (arb_req),
  .sr_req   (sr_req),
  .sr_active(sr_active),
  .miss_err (miss_err),
  .cyc_done (cyc_done),
  .cyc_cbr  (cyc_cbr),
  .row_step (row_step)
);

// File: tb/sim_dram_rfsh_seq.sv
module sim_dram_rfsh_seq;
  localparam int RB = 9;
  localparam int CP = 40;
  localparam int RP = 20;
  localparam int RL = 3;
  localparam int SM = 10;
  localparam int CG = 30;
  localparam int RG = 12;
  localparam int NROWS = 1 << RB;

  logic          clk = 1'b0, rst_n = 1'b0, ras_only = 1'b0, sr_req = 1'b0, arb_gnt = 1'b0;
  logic          arb_req, ras_n, cas_n, addr_en, cyc_done, sr_active, miss_err;
  logic [RB-1:0] row_addr;

  dram_rfsh_seq #(
    .ROW_BITS(RB), .CBR_PERIOD(CP), .RO_PERIOD(RP), .RAS_LOW_CYC(RL),
    .SR_MIN_CYC(SM), .CBR_GAP(CG), .RO_GAP(RG)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ras_only(ras_only), .sr_req(sr_req), .arb_gnt(arb_gnt),
    .arb_req(arb_req), .ras_n(ras_n), .cas_n(cas_n), .addr_en(addr_en),
    .row_addr(row_addr), .cyc_done(cyc_done), .sr_active(sr_active), .miss_err(miss_err)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, n = 0, rowm = 0;
  bit finished = 1'b0;

  always @(posedge clk) if (!rst_n) n <= 0; else n <= n + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, n);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_req();
    while (!arb_req) step();
  endtask

  // Starts at the first strobe sample of a cycle (after grant, or after exit precharge).
  task automatic body(output int fall_n);
    string tag;
    tag = ras_only ? "R5" : "R4";
    if (!ras_only) begin
      chk(cas_n == 1'b0 && ras_n == 1'b1, "R4 cas lead", {cas_n, ras_n}, 2'b01);
      step();
    end
    fall_n = n;
    for (int i = 0; i < RL; i++) begin
      chk(ras_n == 1'b0, {tag, " ras low"}, ras_n, 0);
      chk(cas_n == ras_only, {tag, " cas level"}, cas_n, ras_only);
      chk(addr_en == ras_only, {tag, " addr_en"}, addr_en, ras_only);
      if (ras_only) chk(row_addr == RB'(rowm), "R5 row value", row_addr, rowm);
      chk(arb_req == 1'b1, "R3 req held in cycle", arb_req, 1);
      step();
    end
    chk(ras_n && cas_n && cyc_done, {tag, " precharge"}, {ras_n, cas_n, cyc_done}, 3'b111);
    if (ras_only) rowm = (rowm + 1) % NROWS;
  endtask

  task automatic granted(output int fall_n);
    arb_gnt = 1'b1;
    step();
    arb_gnt = 1'b0;
    body(fall_n);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int f, e, x, prev;
    repeat (3) step();
    // R1: reset state
    chk(ras_n && cas_n, "R1 strobes", {ras_n, cas_n}, 2'b11);
    chk(!arb_req && !addr_en && !cyc_done, "R1 req/addr/done", {arb_req, addr_en, cyc_done}, 0);
    chk(!sr_active && !miss_err, "R1 sr/miss", {sr_active, miss_err}, 0);
    chk(row_addr == '0, "R1 row", row_addr, 0);
    rst_n = 1'b1;
    chk(!arb_req && ras_n, "R1 at release", {arb_req, ras_n}, 1);

    // R2: first CBR interval
    step(); wait_req();
    chk(n == CP, "R2 first interval", n, CP);
    granted(f);
    chk(row_addr == '0, "R6 cbr keeps row", row_addr, 0);
    step();
    chk(arb_req == 1'b0, "R3 req drops after done", arb_req, 0);
    chk(row_addr == '0, "R6 cbr keeps row after", row_addr, 0);
    wait_req();
    chk(n == 2 * CP, "R2 second interval", n, 2 * CP);

    // R3: request waits for grant with idle strobes
    for (int i = 0; i < 5; i++) begin
      chk(arb_req && ras_n && cas_n, "R3 wait for grant", {arb_req, ras_n, cas_n}, 3'b111);
      step();
    end
    granted(f);
    step(); wait_req();
    chk(n == 3 * CP, "R2 third interval", n, 3 * CP);
    granted(f);
    step();

    // R5/R6: RAS-only sweep over every row and past the wrap
    ras_only = 1'b1;
    prev = 0;
    for (int k = 0; k <= NROWS; k++) begin
      wait_req();
      if (k >= 1) chk(n - prev == RP, "R2 ras-only interval", n - prev, RP);
      prev = n;
      granted(f);
      step();
      chk(row_addr == RB'((k + 1) % NROWS), "R6 row step/wrap", row_addr, (k + 1) % NROWS);
    end

    // R8: sr_req away from cycle end is ignored
    sr_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!sr_active && ras_n, "R8 ignored request", {sr_active, ras_n}, 1);
    end
    sr_req = 1'b0;
    wait_req(); granted(f); step();
    chk(!sr_active && ras_n && cas_n, "R8 no entry", {sr_active, ras_n, cas_n}, 3'b011);

    // R9..R12: self refresh in both modes
    for (int m = 0; m < 2; m++) begin
      int lim, per, cnt;
      ras_only = m[0];
      lim = m ? RG : CG;
      per = m ? RP : CP;
      wait_req();
      granted(f);
      step(); wait_req();          // a fresh interval in this mode
      sr_req = 1'b1;
      granted(f);
      step();
      chk(!cas_n && ras_n && sr_active, "R9 cas first", {cas_n, ras_n, sr_active}, 3'b011);
      step();
      chk(!ras_n && !cas_n, "R9 both low", {ras_n, cas_n}, 0);
      chk(n - f == RL + 2 && n - f <= lim, "R9 entry gap", n - f, RL + 2);
      cnt = 0;
      if (m == 0) begin
        sr_req = 1'b0;
        while (!ras_n && cnt < 100) begin cnt++; step(); end
        chk(cnt == SM, "R10 minimum hold", cnt, SM);
      end else begin
        for (int i = 0; i < SM + 6; i++) begin
          chk(!ras_n && sr_active, "R10 hold while requested", ras_n, 0);
          if (i == SM + 5) sr_req = 1'b0;
          step();
        end
      end
      x = n;
      chk(ras_n && cas_n && !sr_active && arb_req, "R11 exit precharge",
          {ras_n, cas_n, sr_active, arb_req}, 4'b1101);
      step();
      body(e);
      chk(e - x == (m ? 1 : 2) && e - x <= lim, "R11 exit gap", e - x, m ? 1 : 2);
      step();
      chk(arb_req == 1'b0, "R11 released after exit cycle", arb_req, 0);
      wait_req();
      chk(n == x + 1 + per, "R12 interval restart", n - x, 1 + per);
      granted(f);
      step();
    end

    // R7: missed deadline, sticky
    wait_req();
    e = n;
    while (n < e + RP - 1) begin
      chk(miss_err == 1'b0, "R7 no early miss", miss_err, 0);
      step();
    end
    step();
    chk(miss_err == 1'b1, "R7 miss raised", miss_err, 1);
    granted(f);
    repeat (2 * RP) step();
    chk(miss_err == 1'b1, "R7 miss sticky", miss_err, 1);
    rst_n = 1'b0;
    step();
    chk(miss_err == 1'b0 && row_addr == '0, "R1 reset clears", {miss_err, row_addr}, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule